// File: doc/BRIEF.md
# LPC I/O Write Target with Per-Channel Input Buffers

This block is the peripheral side of an LPC bus for host I/O write cycles. On every rising edge of the LPC clock it samples the frame strobe and the 4-bit multiplexed address/data lines. It first recognises a start frame and an I/O write cycle type. It then shifts in a 16-bit address and compares it with up to four channel addresses. Only channels that are enabled, under a global enable, take part in the compare.

When a channel matches, the block takes one data byte into that channel's input buffer. After the host's turnaround it drives the sync and release nibbles on the bus. In the same cycle as the second driven nibble, it sets that channel's "buffer full" flag, stores address bit 2 in a per-channel flag, and raises a one-cycle interrupt pulse. A local CPU uses a small byte-wide register port on the same clock. Through it the CPU programs the enables and the addresses, reads the buffers (which clears the full flag) and reads the flags.

Register map (4-bit register address, byte data):

- 0: control. Bit 0 is the global enable, bits 4 to 7 are the enables for channels 0 to 3, and bits 1 to 3 read as 0.
- 1 and 2: channel 1 address, low byte then high byte.
- 3 and 4: channel 2 address, low byte then high byte.
- 5 and 6: channel 3 address, low byte then high byte.
- 8 to 11: input buffers of channels 0 to 3.
- 12: flags. Bits 0 to 3 are the full flags, bits 4 to 7 hold address bit 2 of the last write to each channel.

All other addresses read as 0 and ignore writes.

Top module: `lpc_iowr_target`

## Requirements
- R1: A cycle starts on an edge where `lframe_n`=0 and `lad_i`=4'b0000; while `lframe_n` stays low with 4'b0000 the start is re-taken. The next edge, with `lframe_n`=1, must carry the I/O write type 4'b001x (4'b0010 and 4'b0011 are both accepted).
- R2: The next four nibbles form the address, bits 15:12 first and bits 3:0 last. The two nibbles after that form the data byte, bits 3:0 first. The byte is written into the matching channel's buffer, which is read at register 8+channel.
- R3: Counting the start nibble as bus cycle 1, `lad_oe` is 1 only in cycles 11 and 12 of a matched write. `lad_o` is 4'b0000 in cycle 11 and 4'b1111 in cycle 12. `lad_oe` returns to 0 in cycle 13.
- R4: The matched channel's full flag and address-bit-2 flag take their new values in cycle 12. In that same cycle `irq` bit [channel] is 1, for that one cycle only, and at most one `irq` bit is ever set. Register 12 returns {a2 flags[3:0], full flags[3:0]}.
- R5: A CPU read (`reg_rd`=1) returns its data on `reg_rdata` in the cycle after the edge. A read of register 8+channel clears that channel's full flag at the same edge. If the flag is being set at that same edge, the set wins.
- R6: A channel responds only when control bit 0 and its own enable bit are both 1. Otherwise the write gives no bus drive, no flag change and no interrupt.
- R7: The address of channel 0 is fixed at CH0_ADDR (default 16'h0CA0). Channels 1 to 3 take their addresses from registers 1 to 6, which read back what was written. Registers 7 and 13 to 15 read 0.
- R8: A write whose address matches no enabled channel changes no buffer or flag and never drives the bus. When several channels match, the lowest-numbered one is used.
- R9: `lframe_n` low at any edge aborts the cycle in progress, including during the target's drive. `lad_oe` is then 0 in the next cycle and no flag is set. A start frame at that edge begins a new cycle.
- R10: Any cycle type other than 4'b001x (for example 4'b0000 or 4'b0100) is ignored without drive or flag change.
- R11: Synchronous active-high reset clears the state machine, enables, channel 1 to 3 addresses, buffers, flags, `irq`, `lad_oe` and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | LPC clock, also used by the CPU port |
| rst | input | 1 | Synchronous active-high reset |
| lframe_n | input | 1 | Active-low frame strobe from the host |
| lad_i | input | 4 | Sampled address/data bus nibble |
| lad_o | output | 4 | Nibble the target drives onto the bus |
| lad_oe | output | 1 | Output enable for the bus drivers |
| reg_wr | input | 1 | CPU register write strobe |
| reg_rd | input | 1 | CPU register read strobe |
| reg_addr | input | 4 | CPU register address |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data, valid the cycle after the read |
| ibf | output | 4 | Per-channel buffer-full flags |
| xa2 | output | 4 | Per-channel captured address bit 2 |
| irq | output | 4 | One-cycle per-channel interrupt pulse |

## Verification
The bench targets aborts at different points. One comes during the data phase and one during the sync drive. A design that only checked the strobe in idle would keep driving the bus or would set a flag for a cycle the host abandoned. The bench also sends two-cycle start frames, unsupported cycle types, unmatched addresses, and writes to channels with only one of the two enables set. A decoder that forgot one of the gates would answer them. Writes use address bit 2 set and clear, and the buffer reads fall next to flag updates. This exposes an address-bit-2 flag taken from the wrong bit, a full flag that is not cleared by the read, and a driven nibble or interrupt that is one cycle off.

// File: rtl/lpc_iowr_pkg.sv
package lpc_iowr_pkg;

  localparam int unsigned NIB_W    = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned IO_ADR_W = 16;
  localparam int unsigned ADR_NIBS = IO_ADR_W / NIB_W;
  localparam int unsigned REG_AW   = 4;

  localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_SYNC  = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_ONES  = 4'b1111;
  localparam logic [2:0]       WR_TYPE   = 3'b001;

  localparam logic [REG_AW-1:0] RA_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] RA_DBUF  = 4'd8;
  localparam logic [REG_AW-1:0] RA_FLAGS = 4'd12;

  typedef enum logic [3:0] {
    FS_IDLE,
    FS_CTYPE,
    FS_ADDR,
    FS_DLO,
    FS_DHI,
    FS_TAR0,
    FS_TAR1,
    FS_SYNC,
    FS_READY
  } frame_st_t;

endpackage

// File: rtl/lpc_frame_fsm.sv
module lpc_frame_fsm
  import lpc_iowr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned CNT_W = $clog2(ADR_NIBS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lframe_n,
  input  logic [NIB_W-1:0]    lad_i,
  input  logic [NUM_CH-1:0]   hit_vec,
  output logic [IO_ADR_W-1:0] cyc_addr,
  output logic [NIB_W-1:0]    lad_o,
  output logic                lad_oe,
  output logic                commit,
  output logic [CH_W-1:0]     commit_ch,
  output logic [BYTE_W-1:0]   commit_data,
  output logic                commit_a2
);

  frame_st_t        state;
  logic [CNT_W-1:0] nib_cnt;
  logic [CH_W-1:0]  hit_idx;
  logic [CH_W-1:0]  sel_ch;
  logic [BYTE_W-1:0] data_q;

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FS_IDLE;
      nib_cnt  <= '0;
      cyc_addr <= '0;
      data_q   <= '0;
      sel_ch   <= '0;
      lad_o    <= '0;
      lad_oe   <= 1'b0;
    end else if (!lframe_n) begin
      state  <= (lad_i == NIB_START) ? FS_CTYPE : FS_IDLE;
      lad_oe <= 1'b0;
    end else begin
      unique case (state)
        FS_IDLE: state <= FS_IDLE;
        FS_CTYPE: begin
          nib_cnt <= '0;
          state   <= (lad_i[3:1] == WR_TYPE) ? FS_ADDR : FS_IDLE;
        end
        FS_ADDR: begin
          cyc_addr <= {cyc_addr[IO_ADR_W-NIB_W-1:0], lad_i};
          nib_cnt  <= nib_cnt + 1'b1;
          if (nib_cnt == CNT_W'(ADR_NIBS - 1)) state <= FS_DLO;
        end
        FS_DLO: begin
          data_q[3:0] <= lad_i;
          sel_ch      <= hit_idx;
          state       <= (|hit_vec) ? FS_DHI : FS_IDLE;
        end
        FS_DHI: begin
          data_q[7:4] <= lad_i;
          state       <= FS_TAR0;
        end
        FS_TAR0: state <= FS_TAR1;
        FS_TAR1: begin
          lad_oe <= 1'b1;
          lad_o  <= NIB_SYNC;
          state  <= FS_SYNC;
        end
        FS_SYNC: begin
          lad_o <= NIB_ONES;
          state <= FS_READY;
        end
        FS_READY: begin
          lad_oe <= 1'b0;
          state  <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign commit      = lframe_n && (state == FS_SYNC);
  assign commit_ch   = sel_ch;
  assign commit_data = data_q;
  assign commit_a2   = cyc_addr[2];

  AST_OE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    lad_oe |-> (state == FS_SYNC || state == FS_READY)); // R3
  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(lad_oe) |-> (lad_o == NIB_SYNC)); // R3
  AST_ONES_SECOND: assert property (@(posedge clk) disable iff (rst)
    (lad_oe && $past(lad_oe)) |-> (lad_o == NIB_ONES)); // R3
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !lframe_n |=> !lad_oe); // R9

endmodule

// File: rtl/lpc_chan_cfg.sv
module lpc_chan_cfg
  import lpc_iowr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter logic [IO_ADR_W-1:0] CH0_ADDR = 16'h0CA0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  input  logic [IO_ADR_W-1:0] cyc_addr,
  output logic [NUM_CH-1:0]   hit_vec,
  output logic [BYTE_W-1:0]   cfg_rdata
);

  logic                glb_en;
  logic [NUM_CH-1:0]   ch_en;
  logic [IO_ADR_W-1:0] ch_addr [NUM_CH];
  logic [BYTE_W-1:0]   rd_mux;
  logic                unused_wbits;

  assign unused_wbits = ^reg_wdata[3:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en <= 1'b0;
      ch_en  <= '0;
    end else if (reg_wr && reg_addr == RA_CTRL) begin
      glb_en <= reg_wdata[0];
      ch_en  <= reg_wdata[4 +: NUM_CH];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (g == 0) begin : g_fixed
      always_ff @(posedge clk) begin
        ch_addr[g] <= CH0_ADDR;
      end
    end else begin : g_prog
      localparam logic [REG_AW-1:0] RA_LO = REG_AW'(2 * g - 1);
      localparam logic [REG_AW-1:0] RA_HI = REG_AW'(2 * g);
      always_ff @(posedge clk) begin
        if (rst) begin
          ch_addr[g] <= '0;
        end else if (reg_wr && reg_addr == RA_LO) begin
          ch_addr[g][7:0] <= reg_wdata;
        end else if (reg_wr && reg_addr == RA_HI) begin
          ch_addr[g][15:8] <= reg_wdata;
        end
      end
    end
    assign hit_vec[g] = glb_en && ch_en[g] && (ch_addr[g] == cyc_addr);
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == RA_CTRL) begin
      rd_mux[0]            = glb_en;
      rd_mux[4 +: NUM_CH]  = ch_en;
    end
    for (int i = 1; i < NUM_CH; i++) begin
      if (reg_addr == REG_AW'(2 * i - 1)) rd_mux = ch_addr[i][7:0];
      if (reg_addr == REG_AW'(2 * i))     rd_mux = ch_addr[i][15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else if (reg_rd) cfg_rdata <= rd_mux;
  end

endmodule

// File: rtl/lpc_chan_store.sv
module lpc_chan_store
  import lpc_iowr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [CH_W-1:0]   commit_ch,
  input  logic [BYTE_W-1:0] commit_data,
  input  logic              commit_a2,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  output logic [BYTE_W-1:0] st_rdata,
  output logic [NUM_CH-1:0] ibf,
  output logic [NUM_CH-1:0] xa2,
  output logic [NUM_CH-1:0] irq
);

  logic [BYTE_W-1:0] ibuf [NUM_CH];
  logic [BYTE_W-1:0] rd_mux;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    localparam logic [REG_AW-1:0] RA_MY = RA_DBUF + REG_AW'(g);
    logic take;
    assign take = commit && (commit_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ibuf[g] <= '0;
        ibf[g]  <= 1'b0;
        xa2[g]  <= 1'b0;
        irq[g]  <= 1'b0;
      end else begin
        irq[g] <= take;
        if (take) begin
          ibuf[g] <= commit_data;
          xa2[g]  <= commit_a2;
          ibf[g]  <= 1'b1;
        end else if (reg_rd && reg_addr == RA_MY) begin
          ibf[g] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == RA_FLAGS) begin
      rd_mux[0 +: NUM_CH] = ibf;
      rd_mux[4 +: NUM_CH] = xa2;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == RA_DBUF + REG_AW'(i)) rd_mux = ibuf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_rdata <= '0;
    else if (reg_rd) st_rdata <= rd_mux;
  end

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq)); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|irq) |=> (irq == '0)); // R4
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> ((irq & ibf) == irq)); // R4

endmodule

// File: rtl/lpc_iowr_target.sv
module lpc_iowr_target
  import lpc_iowr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter logic [15:0] CH0_ADDR = 16'h0CA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lframe_n,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [NUM_CH-1:0] ibf,
  output logic [NUM_CH-1:0] xa2,
  output logic [NUM_CH-1:0] irq
);

  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [IO_ADR_W-1:0] cyc_addr;
  logic [NUM_CH-1:0]   hit_vec;
  logic                commit;
  logic [CH_W-1:0]     commit_ch;
  logic [BYTE_W-1:0]   commit_data;
  logic                commit_a2;
  logic [BYTE_W-1:0]   cfg_rdata;
  logic [BYTE_W-1:0]   st_rdata;

  lpc_frame_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .lframe_n    (lframe_n),
    .lad_i       (lad_i),
    .hit_vec     (hit_vec),
    .cyc_addr    (cyc_addr),
    .lad_o       (lad_o),
    .lad_oe      (lad_oe),
    .commit      (commit),
    .commit_ch   (commit_ch),
    .commit_data (commit_data),
    .commit_a2   (commit_a2)
  );

  lpc_chan_cfg #(.NUM_CH(NUM_CH), .CH0_ADDR(CH0_ADDR)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cyc_addr  (cyc_addr),
    .hit_vec   (hit_vec),
    .cfg_rdata (cfg_rdata)
  );

  lpc_chan_store #(.NUM_CH(NUM_CH)) u_store (
    .clk         (clk),
    .rst         (rst),
    .commit      (commit),
    .commit_ch   (commit_ch),
    .commit_data (commit_data),
    .commit_a2   (commit_a2),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .st_rdata    (st_rdata),
    .ibf         (ibf),
    .xa2         (xa2),
    .irq         (irq)
  );

  assign reg_rdata = cfg_rdata | st_rdata;

  AST_NO_IRQ_WHILE_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> lad_oe); // R4

endmodule

// File: tb/lpc_iowr_target_tb.sv
module lpc_iowr_target_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lframe_n = 1'b1;
  logic       host_drv = 1'b0;
  logic [3:0] host_val = 4'hF;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [3:0] lad_i;
  logic [3:0] lad_o;
  logic       lad_oe;
  logic [7:0] reg_rdata;
  logic [3:0] ibf, xa2, irq;

  always #10 clk = ~clk;

  assign lad_i = lad_oe ? lad_o : (host_drv ? host_val : 4'hF);

  lpc_iowr_target dut_i (
    .clk(clk), .rst(rst), .lframe_n(lframe_n), .lad_i(lad_i),
    .lad_o(lad_o), .lad_oe(lad_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ibf(ibf), .xa2(xa2), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  string phase = "R11";

  // behavioural reference
  int         m_pos = 0;
  int         m_hit = -1;
  logic [15:0] m_addr;
  logic [7:0]  m_data;
  logic        m_ge;
  logic [3:0]  m_en;
  logic [15:0] m_caddr [4];
  logic [7:0]  m_buf [4];
  logic [3:0]  m_ibf, m_xa2;
  logic        e_oe;
  logic [3:0]  e_lad, e_irq;
  logic [7:0]  e_rdata;

  function automatic logic [7:0] rd_val(input logic [3:0] a);
    case (a)
      4'd0: return {m_en, 3'b000, m_ge};
      4'd1, 4'd3, 4'd5: return m_caddr[(a + 1) / 2][7:0];
      4'd2, 4'd4, 4'd6: return m_caddr[a / 2][15:8];
      4'd8, 4'd9, 4'd10, 4'd11: return m_buf[a - 8];
      4'd12: return {m_xa2, m_ibf};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step(input logic s_rst, input logic s_lf, input logic [3:0] s_lad,
                            input logic s_rd, input logic s_wr, input logic [3:0] s_a,
                            input logic [7:0] s_wd);
    e_irq = 4'h0;
    if (s_rst) begin
      m_pos = 0; m_hit = -1; m_addr = '0; m_data = '0; m_ge = 0; m_en = '0;
      m_caddr[0] = 16'h0CA0;
      for (int i = 1; i < 4; i++) m_caddr[i] = '0;
      for (int i = 0; i < 4; i++) m_buf[i] = '0;
      m_ibf = '0; m_xa2 = '0; e_oe = 0; e_lad = '0; e_rdata = '0;
      return;
    end
    if (s_rd) begin
      e_rdata = rd_val(s_a);
      if (s_a >= 8 && s_a < 12) m_ibf[s_a - 8] = 1'b0;
    end
    if (!s_lf) begin
      m_pos = (s_lad == 4'h0) ? 1 : 0;
      e_oe = 0;
    end else begin
      case (m_pos)
        1: m_pos = (s_lad[3:1] == 3'b001) ? 2 : 0;
        2, 3, 4, 5: begin m_addr = {m_addr[11:0], s_lad}; m_pos++; end
        6: begin
          m_data[3:0] = s_lad;
          m_hit = -1;
          for (int i = 3; i >= 0; i--)
            if (m_ge && m_en[i] && m_caddr[i] == m_addr) m_hit = i;
          m_pos = (m_hit < 0) ? 0 : 7;
        end
        7: begin m_data[7:4] = s_lad; m_pos = 8; end
        8: m_pos = 9;
        9: begin m_pos = 10; e_oe = 1; e_lad = 4'h0; end
        10: begin
          m_pos = 11; e_lad = 4'hF;
          m_ibf[m_hit] = 1'b1; m_xa2[m_hit] = m_addr[2];
          m_buf[m_hit] = m_data; e_irq[m_hit] = 1'b1;
        end
        11: begin m_pos = 0; e_oe = 0; end
        default: m_pos = 0;
      endcase
    end
    if (s_wr) begin
      if (s_a == 4'd0) begin m_ge = s_wd[0]; m_en = s_wd[7:4]; end
      else if (s_a >= 1 && s_a <= 6) begin
        if (s_a[0]) m_caddr[(s_a + 1) / 2][7:0] = s_wd;
        else        m_caddr[s_a / 2][15:8] = s_wd;
      end
    end
  endtask

  task automatic tick();
    logic s_rst, s_lf, s_rd, s_wr, bad;
    logic [3:0] s_lad, s_a;
    logic [7:0] s_wd;
    @(negedge clk);
    s_rst = rst; s_lf = lframe_n; s_lad = lad_i; s_rd = reg_rd; s_wr = reg_wr;
    s_a = reg_addr; s_wd = reg_wdata;
    @(posedge clk);
    #2;
    model_step(s_rst, s_lf, s_lad, s_rd, s_wr, s_a, s_wd);
    checks++;
    bad = 0;
    if (lad_oe !== e_oe || (e_oe && lad_o !== e_lad)) begin
      bad = 1;
      $display("FAIL R3 [%s] t=%0t oe/lad actual %b/%h expected %b/%h", phase, $time, lad_oe, lad_o, e_oe, e_lad);
    end
    if (irq !== e_irq || ibf !== m_ibf || xa2 !== m_xa2) begin
      bad = 1;
      $display("FAIL R4 [%s] t=%0t irq/ibf/xa2 actual %h/%h/%h expected %h/%h/%h", phase, $time, irq, ibf, xa2, e_irq, m_ibf, m_xa2);
    end
    if ((s_rd || s_rst) && reg_rdata !== e_rdata) begin
      bad = 1;
      $display("FAIL R5 [%s] t=%0t rdata actual %h expected %h", phase, $time, reg_rdata, e_rdata);
    end
    if (bad) failures++;
  endtask

  task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic cpu_rd(input logic [3:0] a);
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // one host I/O write; abort_at > 0 replaces that cycle with a new start frame
  task automatic host_write(input logic [15:0] a, input logic [7:0] d,
                            input logic [3:0] ct, input int abort_at);
    for (int n = 1; n <= 13; n++) begin
      if (n == abort_at) begin
        lframe_n = 0; host_drv = 1; host_val = 4'h0;
        tick();
        lframe_n = 1; host_drv = 0;
        return;
      end
      lframe_n = (n == 1) ? 1'b0 : 1'b1;
      host_drv = (n <= 9);
      case (n)
        1: host_val = 4'h0;
        2: host_val = ct;
        3: host_val = a[15:12];
        4: host_val = a[11:8];
        5: host_val = a[7:4];
        6: host_val = a[3:0];
        7: host_val = d[3:0];
        8: host_val = d[7:4];
        default: host_val = 4'hF;
      endcase
      tick();
    end
    lframe_n = 1; host_drv = 0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    phase = "R11"; rst = 1; tick(); tick(); rst = 0; idle(2);
    cpu_rd(4'd12); cpu_rd(4'd0);

    phase = "R7";
    cpu_wr(4'd0, 8'hF1);
    cpu_wr(4'd1, 8'h60); cpu_wr(4'd2, 8'h00);
    cpu_wr(4'd3, 8'h64); cpu_wr(4'd4, 8'h00);
    cpu_wr(4'd5, 8'hF8); cpu_wr(4'd6, 8'h03);
    cpu_wr(4'd7, 8'hAA);
    for (int r = 0; r < 16; r++) cpu_rd(4'(r));

    phase = "R2";
    host_write(16'h0CA0, 8'h5A, 4'h2, 0);
    cpu_rd(4'd12);
    phase = "R5"; cpu_rd(4'd8); cpu_rd(4'd12);

    phase = "R1";
    host_write(16'h0064, 8'hC3, 4'h3, 0);
    cpu_rd(4'd10);
    lframe_n = 0; host_drv = 1; host_val = 4'h0; tick();
    host_write(16'h0060, 8'h81, 4'h2, 0);

    phase = "R4";
    host_write(16'h03F8, 8'h7E, 4'h2, 0);
    cpu_rd(4'd12); cpu_rd(4'd9); cpu_rd(4'd11); cpu_rd(4'd12);

    phase = "R8";
    host_write(16'h1234, 8'h99, 4'h2, 0);
    host_write(16'h0CA4, 8'h98, 4'h2, 0);
    cpu_rd(4'd12);

    phase = "R6";
    cpu_wr(4'd0, 8'hB1);
    host_write(16'h0064, 8'h66, 4'h2, 0);
    cpu_wr(4'd0, 8'hF0);
    host_write(16'h0CA0, 8'h67, 4'h2, 0);
    cpu_wr(4'd0, 8'hF1);
    cpu_rd(4'd10); cpu_rd(4'd8); cpu_rd(4'd12);

    phase = "R9";
    host_write(16'h0060, 8'h11, 4'h2, 8);
    host_write(16'h0060, 8'h22, 4'h2, 0);
    host_write(16'h03F8, 8'h33, 4'h2, 11);
    idle(2);
    host_write(16'h0064, 8'h44, 4'h2, 12);
    idle(2);
    cpu_rd(4'd12); cpu_rd(4'd9); cpu_rd(4'd11);

    phase = "R10";
    host_write(16'h0CA0, 8'h55, 4'h0, 0);
    host_write(16'h0CA0, 8'h56, 4'h4, 0);
    host_write(16'h0CA0, 8'h57, 4'hA, 0);
    cpu_rd(4'd12); cpu_rd(4'd8);

    phase = "R5";
    host_write(16'h0CA0, 8'h3C, 4'h2, 0);
    cpu_rd(4'd8); cpu_rd(4'd12);

    phase = "R11";
    host_write(16'h0064, 8'hE7, 4'h2, 0);
    rst = 1; tick(); rst = 0;
    cpu_rd(4'd12); cpu_rd(4'd10); cpu_rd(4'd0); cpu_rd(4'd3);
    host_write(16'h0CA0, 8'h12, 4'h2, 0);
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule